// File: doc/BRIEF.md
# Dual-Speed CPU Bus Clock Controller

This block is the glue between a fast 8/16-bit CPU and a system whose peripherals still run on a slow phase-2 clock of about 1 MHz. It runs in the fast clock domain and generates the CPU clock itself. For every bus cycle it looks at the CPU address and direction and picks one of two paths. A fast cycle is served by local SRAM in one fast clock. A slow cycle stalls the CPU clock high until the slow clock rises, then drives the system bus for the whole slow high phase.

After reset every cycle is slow. This lets boot code copy the ROM images into shadow RAM while the CPU runs at the system rate. Software then writes 1 to a speed register placed at a spare I/O address, which enables fast clocking. Peripheral (I/O) accesses stay slow in either mode. A configuration pin can force every write onto the slow path, so that shadow RAM and system RAM stay coherent.

Top module: `dsc_bus_clock`

## Requirements
- R1: While `rst` is high and on the first sample after it, `cpu_clk`, `ram_sel`, `sys_en` and `stall` are all 0. After reset the speed register is 0, so every bus cycle is slow, including reads of the ROM-shadow pages.
- R2: In fast mode, a cycle to a RAM page (address bits 15:12 not 0xA, 0xB, 0xD, 0xE or 0xF) holds `cpu_clk` high for exactly one fast clock with `ram_sel` high, and raises neither `stall` nor `sys_en`.
- R3: In fast mode, reads from the ROM-shadow pages 0xA, 0xB, 0xE and 0xF complete as fast cycles served from RAM (`ram_sel`).
- R4: Every access to page 0xD, the peripheral page, is a slow cycle whatever the mode. `ram_sel` is never high for such an address.
- R5: A slow cycle holds `cpu_clk` high with `stall` high until a rising edge of the synchronized `phi2_in` arrives. It then raises `sys_en` for exactly as many fast clocks as `phi2_in` stays high. `cpu_clk` goes low in the same cycle that `sys_en` falls.
- R6: With `slow_writes` = 1, every write (`rw` = 0) is a slow cycle at any address. Reads behave as with `slow_writes` = 0.
- R7: A completed write to address 0xDFFE loads `wr_bit` into the speed register: 1 selects fast mode and 0 selects slow mode. Reads of 0xDFFE and writes to any other address leave the register unchanged.
- R8: `ram_sel` and `sys_en` are never high together. `ram_sel` is high only in fast cycles and `sys_en` only in slow cycles.
- R9: Each low phase of `cpu_clk` lasts exactly one fast clock, and no `cpu_clk` pulse is shorter than one fast clock period. This holds for slow-to-fast ratios of 4 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, for example derived from the video dot clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2_in | input | 1 | Slow system phase-2 clock, asynchronous to `clk` |
| addr | input | 16 | CPU address, stable for the whole bus cycle |
| rw | input | 1 | CPU direction: 1 = read, 0 = write |
| wr_bit | input | 1 | CPU data bit 0, written into the speed register |
| slow_writes | input | 1 | Configuration: 1 forces all writes onto slow cycles |
| cpu_clk | output | 1 | Generated CPU clock; low = address phase, high = data phase |
| ram_sel | output | 1 | Fast SRAM select, high during a fast data phase |
| sys_en | output | 1 | System bus enable, high during the slow data phase |
| stall | output | 1 | CPU clock held while waiting for the slow clock |

## Verification
The checker tests on every cycle the rules that hold at all times:
- the two selects are mutually exclusive;
- fast selection never happens on the peripheral page or on a forced-slow write;
- a fast data phase and every low phase each last one fast clock;
- `stall` sits only in a held-high clock without either select;
- the slow data phase always ends with the clock going low.

Some properties depend on history or timing, so only the bench scenarios show them:
- the speed register's effect across a sequence of cycles;
- the boot-time slow mode;
- the exact length of `sys_en` matching the slow high period at two clock ratios;
- the full sweep of all sixteen pages, both directions and both write policies.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam logic [3:0]  IO_PAGE      = 4'hD;
    // one bit per 4 KiB page; pages F, E, B, A hold shadowed ROM
    localparam logic [15:0] ROM_PAGE_MAP = 16'b1100_1100_0000_0000;

    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_ROM = 2'd1,
        RGN_IO  = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        PH_LOW     = 2'd0,
        PH_FAST_HI = 2'd1,
        PH_WAIT    = 2'd2,
        PH_SLOW_HI = 2'd3
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } phi_edge_t;

    typedef struct packed {
        logic cpu_clk;
        logic ram_sel;
        logic sys_en;
        logic stall;
    } bus_ctl_t;

    function automatic region_e classify(input logic [3:0] page);
        if (page == IO_PAGE)          return RGN_IO;
        else if (ROM_PAGE_MAP[page])  return RGN_ROM;
        else                          return RGN_RAM;
    endfunction

    function automatic logic wants_slow(input region_e rgn, input logic is_write,
                                        input logic fast_en, input logic slow_writes);
        return !fast_en || (rgn == RGN_IO) || (slow_writes && is_write);
    endfunction

    function automatic bus_ctl_t drive_for(input phase_e ph);
        bus_ctl_t c;
        c = '0;
        case (ph)
            PH_FAST_HI: begin c.cpu_clk = 1'b1; c.ram_sel = 1'b1; end
            PH_WAIT:    begin c.cpu_clk = 1'b1; c.stall   = 1'b1; end
            PH_SLOW_HI: begin c.cpu_clk = 1'b1; c.sys_en  = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsc_phi_sync.sv
module dsc_phi_sync
    import dsc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      phi2_in,
    output phi_edge_t edges
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], phi2_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign edges.rise = chain[STAGES-1] & ~prev;
    assign edges.fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/dsc_speed_reg.sv
module dsc_speed_reg #(
    parameter int               AW    = 16,
    parameter logic [AW-1:0]    MATCH = 16'hDFFE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cycle_end,
    input  logic          is_write,
    input  logic [AW-1:0] addr,
    input  logic          wr_bit,
    output logic          fast_en
);
    logic hit;
    assign hit = cycle_end && is_write && (addr == MATCH);

    always_ff @(posedge clk) begin
        if (rst)      fast_en <= 1'b0;
        else if (hit) fast_en <= wr_bit;
    end
endmodule

// File: rtl/dsc_cycle_fsm.sv
module dsc_cycle_fsm
    import dsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      slow_req,
    input  phi_edge_t edges,
    output phase_e    phase
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_LOW:     nxt = slow_req ? PH_WAIT : PH_FAST_HI;
            PH_FAST_HI: nxt = PH_LOW;
            PH_WAIT:    if (edges.rise) nxt = PH_SLOW_HI;
            PH_SLOW_HI: if (edges.fall) nxt = PH_LOW;
            default:    nxt = PH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_LOW;
        else     phase <= nxt;
    end
endmodule

// File: rtl/dsc_bus_clock.sv
module dsc_bus_clock
    import dsc_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] SPEED_ADDR  = 16'hDFFE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phi2_in,
    input  logic [AW-1:0] addr,
    input  logic          rw,
    input  logic          wr_bit,
    input  logic          slow_writes,
    output logic          cpu_clk,
    output logic          ram_sel,
    output logic          sys_en,
    output logic          stall
);
    localparam int PAGE_W = 4;

    phi_edge_t edges;
    phase_e    phase;
    region_e   rgn;
    bus_ctl_t  ctl;
    logic      fast_en;
    logic      slow_req;
    logic      slow_done;

    dsc_phi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .phi2_in (phi2_in),
        .edges   (edges)
    );

    assign rgn       = classify(addr[AW-1 -: PAGE_W]);
    assign slow_req  = wants_slow(rgn, !rw, fast_en, slow_writes);
    assign slow_done = (phase == PH_SLOW_HI) && edges.fall;

    dsc_speed_reg #(.AW(AW), .MATCH(SPEED_ADDR)) u_speed (
        .clk       (clk),
        .rst       (rst),
        .cycle_end (slow_done),
        .is_write  (!rw),
        .addr      (addr),
        .wr_bit    (wr_bit),
        .fast_en   (fast_en)
    );

    dsc_cycle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .slow_req (slow_req),
        .edges    (edges),
        .phase    (phase)
    );

    assign ctl     = drive_for(phase);
    assign cpu_clk = ctl.cpu_clk;
    assign ram_sel = ctl.ram_sel;
    assign sys_en  = ctl.sys_en;
    assign stall   = ctl.stall;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          rw,
    input logic          slow_writes,
    input logic          cpu_clk,
    input logic          ram_sel,
    input logic          sys_en,
    input logic          stall
);
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(ram_sel && sys_en)); // R8
    AST_IO_NEVER_FAST: assert property (@(posedge clk) disable iff (rst) ram_sel |-> (addr[AW-1 -: 4] != 4'hD)); // R4
    AST_FORCED_WRITE_SLOW: assert property (@(posedge clk) disable iff (rst) (ram_sel && slow_writes) |-> rw); // R6
    AST_FAST_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) ram_sel |=> !cpu_clk); // R2
    AST_LOW_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) !cpu_clk |=> cpu_clk); // R9
    AST_STALL_HELD_HIGH: assert property (@(posedge clk) disable iff (rst) stall |-> (cpu_clk && !ram_sel && !sys_en)); // R5
    AST_SLOW_ENDS_LOW: assert property (@(posedge clk) disable iff (rst) $fell(sys_en) |-> !cpu_clk); // R5
    AST_SYS_AFTER_STALL: assert property (@(posedge clk) disable iff (rst) $rose(sys_en) |-> $past(stall)); // R5
endmodule

bind dsc_bus_clock dsc_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .rw          (rw),
    .slow_writes (slow_writes),
    .cpu_clk     (cpu_clk),
    .ram_sel     (ram_sel),
    .sys_en      (sys_en),
    .stall       (stall)
);

// File: tb/dsc_bus_clock_bench.sv
`timescale 1ns/100ps
module dsc_bus_clock_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rw = 1'b1;
    logic        wr_bit = 1'b0;
    logic        slow_writes = 1'b0;
    logic        cpu_clk, ram_sel, sys_en, stall;

    int checks = 0;
    int failures = 0;
    int phi_h = 4;
    bit done = 1'b0;

    dsc_bus_clock u_dsc_bus_clock (
        .clk(clk), .rst(rst), .phi2_in(phi2), .addr(addr), .rw(rw),
        .wr_bit(wr_bit), .slow_writes(slow_writes),
        .cpu_clk(cpu_clk), .ram_sel(ram_sel), .sys_en(sys_en), .stall(stall)
    );

    initial forever #2.5 clk = ~clk;

    initial begin
        #5;
        forever begin
            #(phi_h * 5.0);
            phi2 = ~phi2;
        end
    end

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Call at a clk negedge with cpu_clk low; returns at the next such negedge.
    task automatic bus_cycle(input logic [15:0] a, input logic r, input logic b,
                             input bit exp_fast, input bit do_check, input string tag);
        int hi, rs, se, st;
        bit ok;
        addr = a; rw = r; wr_bit = b;
        hi = 0; rs = 0; se = 0; st = 0;
        @(negedge clk);
        while (cpu_clk) begin
            hi++;
            if (ram_sel) rs++;
            if (sys_en) se++;
            if (stall) st++;
            @(negedge clk);
        end
        if (do_check) begin
            if (exp_fast)
                ok = (hi == 1) && (rs == 1) && (se == 0) && (st == 0);
            else
                ok = (rs == 0) && (se == phi_h) && (st >= 1) && (st <= 2*phi_h + 3) && (hi == st + se);
            check(ok, tag,
                  $sformatf("a=%h hi=%0d ram=%0d sys=%0d stall=%0d", a, hi, rs, se, st),
                  exp_fast ? "hi=1 ram=1 sys=0 stall=0" : $sformatf("ram=0 sys=%0d stall>=1", phi_h));
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check({cpu_clk, ram_sel, sys_en, stall} == 4'b0000, "R1 in reset",
              $sformatf("%b", {cpu_clk, ram_sel, sys_en, stall}), "0000");
        rst = 1'b0;
        check({cpu_clk, ram_sel, sys_en, stall} == 4'b0000, "R1 after reset",
              $sformatf("%b", {cpu_clk, ram_sel, sys_en, stall}), "0000");

        // boot: everything slow
        bus_cycle(16'h1000, 1'b1, 1'b0, 1'b0, 1'b1, "R1 RAM read slow at boot");
        bus_cycle(16'hE000, 1'b1, 1'b0, 1'b0, 1'b1, "R1 ROM read slow at boot");
        // R7: register untouched by wrong address or reads
        bus_cycle(16'hDFFD, 1'b0, 1'b1, 1'b0, 1'b1, "R7 near-miss write");
        bus_cycle(16'h2000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 still slow after near-miss");
        bus_cycle(16'hDFFE, 1'b1, 1'b1, 1'b0, 1'b1, "R7 read of speed reg");
        bus_cycle(16'h2000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 still slow after read");
        bus_cycle(16'hDFFE, 1'b0, 1'b0, 1'b0, 1'b1, "R7 write 0");
        bus_cycle(16'h2000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 still slow after write 0");
        bus_cycle(16'hDFFE, 1'b0, 1'b1, 1'b0, 1'b1, "R7 enable write");
        bus_cycle(16'h2000, 1'b1, 1'b0, 1'b1, 1'b1, "R7 fast after enable");

        // R9: sweep two clock ratios, both write policies, all pages, both directions
        for (int ri = 0; ri < 2; ri++) begin
            phi_h = (ri == 0) ? 2 : 4;
            bus_cycle(16'hD000, 1'b1, 1'b0, 1'b0, 1'b0, "flush");
            bus_cycle(16'hD000, 1'b1, 1'b0, 1'b0, 1'b0, "flush");
            for (int sw = 0; sw < 2; sw++) begin
                slow_writes = sw[0];
                for (int pg = 0; pg < 16; pg++) begin
                    for (int d = 0; d < 2; d++) begin
                        logic [15:0] a;
                        bit rom, f;
                        string tg;
                        a = {pg[3:0], 12'h123};
                        rom = (pg == 10) || (pg == 11) || (pg == 14) || (pg == 15);
                        f = (pg != 13) && !(sw == 1 && d == 0);
                        if (pg == 13)              tg = "R4 peripheral page slow";
                        else if (sw == 1 && d == 0) tg = "R6 forced slow write";
                        else if (rom && d == 1)    tg = "R3 shadow ROM read fast";
                        else                       tg = "R2 fast RAM cycle";
                        bus_cycle(a, d[0], 1'b0, f, 1'b1,
                                  $sformatf("%s R9 ratio=%0d sw=%0d", tg, 2*phi_h, sw));
                    end
                end
            end
        end
        slow_writes = 1'b0;

        bus_cycle(16'hDFFE, 1'b0, 1'b0, 1'b0, 1'b1, "R7 disable write");
        bus_cycle(16'h2000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 slow after disable");
        bus_cycle(16'hA000, 1'b1, 1'b0, 1'b0, 1'b1, "R5 ROM read slow after disable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule